// File: doc/BRIEF.md
# Receive Descriptor Fetch Controller

This block drives the receive half of a descriptor-based DMA engine. Software builds a list of four-word descriptors in memory, programs the list base, and sets the run control. The controller then walks the list. It reads a descriptor, checks whether the engine owns it, and hands the buffer address and length of an owned descriptor to a frame writer. When the writer reports a finished frame, the controller writes the frame length and error flag back into the descriptor, which also returns ownership to software. It then moves to the next descriptor, or back to the base when the descriptor is marked as the last of the ring.

The receive process has three visible states: Stopped, Running and Suspended. A descriptor that the engine does not own sends it to Suspended and raises a sticky no-buffer flag. A poll-demand write wakes it again at the same descriptor. Clearing the run control lets the current frame finish and then stops the engine. The list position is kept, so the next start resumes where the engine left off.

Top module: `rx_desc_ctrl`

## Requirements
- R1: After reset the status register reads zero (state Stopped, no-buffer flag clear), and `mem_req` and `buf_valid` are low.
- R2: A start (a control write, register index 0, with bit 0 set) issued while Stopped fetches descriptor word 0 at the current list position. No other event moves the engine from Stopped to Running.
- R3: For an owned descriptor (word 0 bit 31 set), the engine reads word 1 (byte offset 4, length in bits 13:0) and word 2 (byte offset 8, buffer address). It then holds `buf_valid` with `buf_addr` and `buf_len` stable until `frame_done`.
- R4: On `frame_done` the engine writes word 0 of the current descriptor as follows: bit 31 cleared, bit 30 kept, bit 15 set to the frame error flag, and bits 13:0 set to the frame length.
- R5: After the write-back, the list position advances by 16 bytes. If word 0 bit 30 (ring end) was set, it returns to the programmed base instead.
- R6: A fetched word 0 with bit 31 clear moves the engine to Suspended. The status register then reads state code 2 in bits 1:0 and the no-buffer flag at bit 7. In this state no memory access is made and `buf_valid` stays low.
- R7: The no-buffer flag is cleared only by a status write (index 2) with bit 7 set. A write with bit 7 clear leaves it set. If a new unowned descriptor is detected in the same cycle as a clearing write, the flag stays set.
- R8: A poll-demand write (index 3) while Suspended refetches word 0 of the same descriptor. In Running or Stopped it has no effect.
- R9: A start command issued while Running or Suspended has no effect on state or on memory traffic.
- R10: Clearing control bit 0 while a frame is in progress lets that frame complete and be written back. The engine then enters Stopped without fetching again, and the next start resumes at the retained position.
- R11: Clearing control bit 0 while Suspended returns the engine to Stopped within two cycles.
- R12: Writing the base register (index 1) while Stopped sets the list position to that base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register index: 0 control, 1 base, 2 status, 3 poll demand |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| mem_req | output | 1 | Descriptor memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the descriptor word |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| buf_valid | output | 1 | Buffer offered to the frame writer |
| buf_addr | output | ADDR_W | Buffer address of the current descriptor |
| buf_len | output | LEN_W | Buffer length of the current descriptor |
| frame_done | input | 1 | Frame writer finished the current frame |
| frame_len | input | LEN_W | Received frame length |
| frame_err | input | 1 | Received frame had an error |

## Verification
The no-buffer flag has two writers: software clears it by writing one, and the engine sets it when a fetched descriptor is unowned. Both can land on the same edge. The bench provokes this by holding back the memory acknowledge for a poll-triggered fetch of an unowned descriptor. It then releases the acknowledge in the same cycle that a clearing status write is presented. The outcome is judged by reading the status register afterwards: bit 7 must still be set and the state must read Suspended. The whole list walk is repeated for memory latencies of zero, one and two wait cycles.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_BASE = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_POLL = 2'd3;

    localparam logic [1:0] ST_STOPPED   = 2'd0;
    localparam logic [1:0] ST_RUNNING   = 2'd1;
    localparam logic [1:0] ST_SUSPENDED = 2'd2;

    localparam int OWN_POS   = 31;
    localparam int RING_POS  = 30;
    localparam int ERR_POS   = 15;
    localparam int NOBUF_POS = 7;
    localparam int RUN_POS   = 0;

    typedef enum logic [2:0] {
        E_IDLE   = 3'd0,
        E_RD_CTL = 3'd1,
        E_RD_LEN = 3'd2,
        E_RD_BUF = 3'd3,
        E_WAIT   = 3'd4,
        E_WB     = 3'd5,
        E_SUSP   = 3'd6
    } eng_state_e;

endpackage

// File: rtl/rxd_csr.sv
module rxd_csr
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [1:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    input  logic [1:0]        run_state,
    input  logic              nobuf_set,
    output logic [31:0]       csr_rdata,
    output logic              run_en,
    output logic [ADDR_W-1:0] list_base,
    output logic              start_cmd,
    output logic              poll_cmd,
    output logic              base_wr,
    output logic              nobuf_flag
);

    typedef struct packed {
        logic              run;
        logic [ADDR_W-1:0] base;
        logic              nobuf;
    } csr_t;

    csr_t q, d;
    logic wr_ctrl, wr_stat;

    always_comb begin
        wr_ctrl   = csr_wr && (csr_addr == REG_CTRL);
        wr_stat   = csr_wr && (csr_addr == REG_STAT);
        base_wr   = csr_wr && (csr_addr == REG_BASE);
        poll_cmd  = csr_wr && (csr_addr == REG_POLL);
        start_cmd = wr_ctrl && csr_wdata[RUN_POS];

        d = q;
        if (wr_ctrl) d.run = csr_wdata[RUN_POS];
        if (base_wr) d.base = csr_wdata[ADDR_W-1:0];
        if (wr_stat && csr_wdata[NOBUF_POS]) d.nobuf = 1'b0;
        // a fresh detection outranks a simultaneous clear
        if (nobuf_set) d.nobuf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            REG_CTRL: csr_rdata[RUN_POS] = q.run;
            REG_BASE: csr_rdata[ADDR_W-1:0] = q.base;
            REG_STAT: begin
                csr_rdata[NOBUF_POS] = q.nobuf;
                csr_rdata[1:0]       = run_state;
            end
            default:  csr_rdata = '0;
        endcase
    end

    assign run_en     = q.run;
    assign list_base  = q.base;
    assign nobuf_flag = q.nobuf;

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 14,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              start_cmd,
    input  logic              poll_cmd,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic [ADDR_W-1:0] list_base,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              frame_done,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              frame_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              buf_valid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  buf_len,
    output logic              nobuf_set,
    output logic [1:0]        run_state
);

    localparam int WORD_BYTES = 4;
    localparam logic [ADDR_W-1:0] OFF_LEN = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] OFF_BUF = ADDR_W'(2 * WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(DESC_BYTES);

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic              ring;
        logic [LEN_W-1:0]  blen;
        logic [ADDR_W-1:0] baddr;
        logic [LEN_W-1:0]  flen;
        logic              ferr;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.ptr;
        mem_wdata = '0;
        nobuf_set = 1'b0;
        case (q.st)
            E_IDLE: begin
                if (base_wr)   d.ptr = base_wdata;
                if (start_cmd) d.st  = E_RD_CTL;
            end
            E_RD_CTL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (mem_rdata[OWN_POS]) begin
                        d.ring = mem_rdata[RING_POS];
                        d.st   = E_RD_LEN;
                    end else begin
                        nobuf_set = 1'b1;
                        d.st      = E_SUSP;
                    end
                end
            end
            E_RD_LEN: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + OFF_LEN;
                if (mem_ack) begin
                    d.blen = mem_rdata[LEN_W-1:0];
                    d.st   = E_RD_BUF;
                end
            end
            E_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + OFF_BUF;
                if (mem_ack) begin
                    d.baddr = mem_rdata[ADDR_W-1:0];
                    d.st    = E_WAIT;
                end
            end
            E_WAIT: begin
                if (frame_done) begin
                    d.flen = frame_len;
                    d.ferr = frame_err;
                    d.st   = E_WB;
                end
            end
            E_WB: begin
                mem_req               = 1'b1;
                mem_we                = 1'b1;
                mem_wdata[RING_POS]   = q.ring;
                mem_wdata[ERR_POS]    = q.ferr;
                mem_wdata[LEN_W-1:0]  = q.flen;
                if (mem_ack) begin
                    d.ptr = q.ring ? list_base : q.ptr + STEP;
                    d.st  = run_en ? E_RD_CTL : E_IDLE;
                end
            end
            E_SUSP: begin
                if (!run_en)       d.st = E_IDLE;
                else if (poll_cmd) d.st = E_RD_CTL;
            end
            default: d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        buf_valid = (q.st == E_WAIT);
        buf_addr  = q.baddr;
        buf_len   = q.blen;
        case (q.st)
            E_IDLE:  run_state = ST_STOPPED;
            E_SUSP:  run_state = ST_SUSPENDED;
            default: run_state = ST_RUNNING;
        endcase
    end

endmodule

// File: rtl/rx_desc_ctrl.sv
module rx_desc_ctrl
    import rxd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 14,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [1:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              buf_valid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  buf_len,
    input  logic              frame_done,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              frame_err
);

    logic              run_en_w, start_w, poll_w, base_wr_w, nobuf_set_w, nobuf_w;
    logic [ADDR_W-1:0] base_w;
    logic [1:0]        run_state_w;

    rxd_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_wr     (csr_wr),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .run_state  (run_state_w),
        .nobuf_set  (nobuf_set_w),
        .csr_rdata  (csr_rdata),
        .run_en     (run_en_w),
        .list_base  (base_w),
        .start_cmd  (start_w),
        .poll_cmd   (poll_w),
        .base_wr    (base_wr_w),
        .nobuf_flag (nobuf_w)
    );

    rxd_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DESC_BYTES(DESC_BYTES)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en_w),
        .start_cmd  (start_w),
        .poll_cmd   (poll_w),
        .base_wr    (base_wr_w),
        .base_wdata (csr_wdata[ADDR_W-1:0]),
        .list_base  (base_w),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .frame_done (frame_done),
        .frame_len  (frame_len),
        .frame_err  (frame_err),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .buf_valid  (buf_valid),
        .buf_addr   (buf_addr),
        .buf_len    (buf_len),
        .nobuf_set  (nobuf_set_w),
        .run_state  (run_state_w)
    );

endmodule

// File: rtl/rxd_checker.sv
module rxd_checker
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr,
    input logic [1:0]        csr_addr,
    input logic [31:0]       csr_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_wdata,
    input logic              buf_valid,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [1:0]        run_state,
    input logic              nobuf_flag
);

    // R2: leaving Stopped for Running needs a start write on the previous edge
    p_start_from_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_state) == ST_STOPPED && run_state == ST_RUNNING)
        |-> $past(csr_wr && csr_addr == REG_CTRL && csr_wdata[RUN_POS]));

    // R3: offered buffer address is held while offered
    p_bufaddr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && $past(buf_valid)) |-> $stable(buf_addr));

    // R4: every write-back returns ownership
    p_wb_own_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[OWN_POS]);

    // R6: entering Suspended comes with the no-buffer flag
    p_susp_raises_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_state == ST_SUSPENDED) |-> nobuf_flag);

    // R6: Suspended is quiet
    p_susp_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_SUSPENDED) |-> (!mem_req && !buf_valid));

    // R7: the flag only falls after a clearing status write
    p_flag_clear_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nobuf_flag) |-> $past(csr_wr && csr_addr == REG_STAT && csr_wdata[NOBUF_POS]));

    // R8: waking from Suspended needs a poll write
    p_poll_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_state) == ST_SUSPENDED && run_state == ST_RUNNING)
        |-> $past(csr_wr && csr_addr == REG_POLL));

    // R10: Stopped is quiet
    p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_STOPPED) |-> (!mem_req && !buf_valid));

endmodule

bind rx_desc_ctrl rxd_checker #(.ADDR_W(ADDR_W)) u_rxd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_wr     (csr_wr),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .buf_valid  (buf_valid),
    .buf_addr   (buf_addr),
    .run_state  (run_state_w),
    .nobuf_flag (nobuf_w)
);

// File: tb/tb_rx_desc_ctrl.sv
module tb_rx_desc_ctrl;
    import rxd_pkg::*;

    localparam int AW = 16;
    localparam int LW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_wr = 1'b0;
    logic [1:0]    csr_addr = REG_STAT;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          buf_valid;
    logic [AW-1:0] buf_addr;
    logic [LW-1:0] buf_len;
    logic          frame_done = 1'b0;
    logic [LW-1:0] frame_len = '0;
    logic          frame_err = 1'b0;

    logic [31:0]   mem [0:63];
    logic [AW-1:0] rd_log [0:63];
    int            rd_n = 0;
    int            lat = 0;
    int            wcnt = 0;
    logic          mem_hold = 1'b0;
    int            checks = 0;
    int            fails = 0;

    always #2.5 clk = ~clk;

    rx_desc_ctrl #(.ADDR_W(AW), .LEN_W(LW), .DESC_BYTES(16)) dut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .buf_valid(buf_valid),
        .buf_addr(buf_addr), .buf_len(buf_len), .frame_done(frame_done),
        .frame_len(frame_len), .frame_err(frame_err)
    );

    // memory responder: one acknowledge per request after lat wait cycles
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0;
                wcnt    = 0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wcnt >= lat && !mem_hold) begin
                    mem_ack = 1'b1;
                    wcnt    = 0;
                    if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                    else begin
                        mem_rdata         = mem[mem_addr[7:2]];
                        rd_log[rd_n % 64] = mem_addr;
                        rd_n++;
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (lat %0d): actual %h expected %h", tag, what, lat, act, exp);
        end
    endtask

    task automatic csr_write(logic [1:0] a, logic [31:0] v);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0; csr_addr = REG_STAT; csr_wdata = '0;
    endtask

    task automatic finish_frame(int len, bit err);
        @(negedge clk);
        frame_done = 1'b1; frame_len = LW'(len); frame_err = err;
        @(negedge clk);
        frame_done = 1'b0; frame_len = '0; frame_err = 1'b0;
    endtask

    task automatic wait_bv(bit v);
        for (int i = 0; i < 200; i++) begin
            if (buf_valid == v) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_state(logic [1:0] s);
        for (int i = 0; i < 200; i++) begin
            if (csr_rdata[1:0] == s) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_scenario();
        int rdn;
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        // desc A at 0x40, desc B at 0x50 (ring end)
        mem[16] = 32'h8000_0000; mem[17] = 32'd100; mem[18] = 32'h0000_1000;
        mem[20] = 32'hC000_0000; mem[21] = 32'd200; mem[22] = 32'h0000_2000;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "status after reset", csr_rdata, 32'h0);
        check_eq("R1", "mem_req/buf_valid after reset", {30'd0, mem_req, buf_valid}, 32'h0);

        csr_write(REG_BASE, 32'h40);
        rdn = rd_n;
        csr_write(REG_CTRL, 32'h1);
        wait_bv(1'b1);
        check_eq("R2", "first fetch address", 32'(rd_log[rdn % 64]), 32'h40);
        check_eq("R3", "length word address", 32'(rd_log[(rdn + 1) % 64]), 32'h44);
        check_eq("R3", "buffer word address", 32'(rd_log[(rdn + 2) % 64]), 32'h48);
        check_eq("R3", "buf_addr", 32'(buf_addr), 32'h1000);
        check_eq("R3", "buf_len", 32'(buf_len), 32'd100);
        check_eq("R3", "state running", csr_rdata, 32'h1);

        rdn = rd_n;
        finish_frame(60, 1'b1);
        wait_bv(1'b0);
        wait_bv(1'b1);
        check_eq("R4", "write-back of A", mem[16], 32'h0000_803C);
        check_eq("R5", "next descriptor +16", 32'(rd_log[rdn % 64]), 32'h50);
        check_eq("R3", "buf_addr of B", 32'(buf_addr), 32'h2000);
        check_eq("R3", "buf_len of B", 32'(buf_len), 32'd200);

        rdn = rd_n;
        finish_frame(70, 1'b0);
        wait_state(ST_SUSPENDED);
        check_eq("R4", "write-back of B keeps ring", mem[20], 32'h4000_0046);
        check_eq("R5", "ring end wraps to base", 32'(rd_log[rdn % 64]), 32'h40);
        check_eq("R6", "suspended with flag", csr_rdata, 32'h82);
        check_eq("R6", "no buffer offered", 32'(buf_valid), 32'h0);

        rdn = rd_n;
        csr_write(REG_CTRL, 32'h1);
        idle(8);
        check_eq("R9", "start in Suspended: no fetch", rd_n, rdn);
        check_eq("R9", "start in Suspended: state kept", csr_rdata, 32'h82);

        csr_write(REG_STAT, 32'h7F);
        check_eq("R7", "write without bit 7 keeps flag", csr_rdata, 32'h82);
        csr_write(REG_STAT, 32'h80);
        check_eq("R7", "write-one clears flag", csr_rdata, 32'h02);

        rdn = rd_n;
        csr_write(REG_POLL, 32'h0);
        idle(10);
        check_eq("R8", "poll refetches one word", rd_n, rdn + 1);
        check_eq("R8", "poll refetch address", 32'(rd_log[rdn % 64]), 32'h40);
        check_eq("R6", "resuspended with flag", csr_rdata, 32'h82);

        // clear and fresh detection on the same edge
        csr_write(REG_STAT, 32'h80);
        mem_hold = 1'b1;
        csr_write(REG_POLL, 32'h0);
        idle(3);
        check_eq("R8", "fetch pending after poll", 32'(mem_req), 32'h1);
        @(posedge clk);
        #1 mem_hold = 1'b0;
        csr_write(REG_STAT, 32'h80);
        idle(1);
        check_eq("R7", "set wins over clear", csr_rdata, 32'h82);

        mem[16] = 32'h8000_0000;
        rdn = rd_n;
        csr_write(REG_POLL, 32'h0);
        wait_bv(1'b1);
        check_eq("R8", "poll resumes same descriptor", 32'(rd_log[rdn % 64]), 32'h40);
        check_eq("R8", "running again", csr_rdata, 32'h81);
        rdn = rd_n;
        csr_write(REG_POLL, 32'h0);
        idle(6);
        check_eq("R8", "poll while Running ignored", {rd_n[30:0], buf_valid}, {rdn[30:0], 1'b1});

        csr_write(REG_CTRL, 32'h0);
        idle(4);
        check_eq("R10", "frame still offered after stop", 32'(buf_valid), 32'h1);
        rdn = rd_n;
        finish_frame(80, 1'b0);
        wait_state(ST_STOPPED);
        idle(6);
        check_eq("R10", "last frame written back", mem[16], 32'h0000_0050);
        check_eq("R10", "no fetch after stop", rd_n, rdn);
        check_eq("R10", "stopped", csr_rdata, 32'h80);

        rdn = rd_n;
        csr_write(REG_CTRL, 32'h1);
        wait_state(ST_SUSPENDED);
        check_eq("R10", "restart at retained position", 32'(rd_log[rdn % 64]), 32'h50);

        csr_write(REG_CTRL, 32'h0);
        idle(2);
        check_eq("R11", "stop from Suspended", 32'(csr_rdata[1:0]), 32'(ST_STOPPED));

        mem[32] = 32'hC000_0000; mem[33] = 32'd30; mem[34] = 32'h0000_3000;
        csr_write(REG_BASE, 32'h80);
        rdn = rd_n;
        csr_write(REG_CTRL, 32'h1);
        wait_bv(1'b1);
        check_eq("R12", "new base used", 32'(rd_log[rdn % 64]), 32'h80);
        check_eq("R12", "buf_addr at new base", 32'(buf_addr), 32'h3000);
        check_eq("R12", "buf_len at new base", 32'(buf_len), 32'd30);

        rdn = rd_n;
        csr_write(REG_CTRL, 32'h1);
        idle(6);
        check_eq("R9", "start while Running ignored", {rd_n[30:0], buf_valid}, {rdn[30:0], 1'b1});

        rdn = rd_n;
        finish_frame(10, 1'b0);
        wait_state(ST_SUSPENDED);
        check_eq("R5", "wrap to reprogrammed base", 32'(rd_log[rdn % 64]), 32'h80);
        check_eq("R4", "write-back at new base", mem[32], 32'h4000_000A);
    endtask

    initial begin
        for (int l = 0; l < 3; l++) begin
            lat = l;
            run_scenario();
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule